// File: doc/BRIEF.md
# Host Mailbox FIFO Register Interface

This block joins a byte-wide host register bus to an embedded controller through two FIFOs. Bytes the host writes to the data register go into a host-to-controller FIFO. The controller drains that FIFO through a valid/ready stream. Bytes the controller offers on a second valid/ready stream go into a controller-to-host FIFO. The host drains that FIFO by reading the data register. A control/status register sits at its own offset. It tells the host whether a byte is waiting to be read, whether the outgoing FIFO has reached its almost-full level, and whether a host write was ever lost.

The host follows a polling scheme. It reads the status register and checks the read-side flag before each data read. It checks the almost-full flag before it sends a burst of up to sixteen bytes. At run time the host can move the almost-full level in steps of sixteen. It does this with a two-write command sequence to the control register.

Back-pressure follows these rules. The controller's incoming stream transfers a byte in any cycle where `ctl_in_valid` and `ctl_in_ready` are both high, and `ctl_in_ready` is low exactly while the controller-to-host FIFO is full. The outgoing stream presents the oldest byte with `ctl_out_valid` high whenever the host-to-controller FIFO holds data. That byte is removed in a cycle where `ctl_out_ready` is also high. The host side has no handshake, so it uses the status flags instead.

Top module: `mbx_host_mailbox`

## Requirements
- R1: The data register is at offset 1 and the control/status register is at offset 3. Reads of offsets 0 and 2 return 0x00, and host writes to them have no effect.
- R2: Each host write to offset 1 that is not dropped appends `host_wdata` to the host-to-controller FIFO. The controller sees the bytes in write order on `ctl_out_data` with `ctl_out_valid` high, and the head byte is removed in each cycle where `ctl_out_valid` and `ctl_out_ready` are both high.
- R3: The host-to-controller FIFO holds 272 bytes. A host write to offset 1 while the FIFO holds 272 bytes at the start of that cycle is dropped. Such a write sets status bit 0, and bit 0 stays at 1 until reset.
- R4: The controller-to-host FIFO holds 16 bytes. `ctl_in_ready` is 0 exactly while it is full, and a byte is accepted only when `ctl_in_valid` and `ctl_in_ready` are both high.
- R5: A host read of offset 1 while the controller-to-host FIFO is non-empty returns the oldest byte on `host_rdata` from the clock edge that samples the read, and removes that byte.
- R6: A host read of offset 1 while the controller-to-host FIFO is empty returns 0xFF and changes no FIFO state.
- R7: Status bit 5 reads 1 when the controller-to-host FIFO is empty and 0 when it holds data.
- R8: Status bit 4 reads 1 when the host-to-controller FIFO count is at or above the almost-full level and 0 below it. The level is 16 after reset.
- R9: A control write of 5, made with no command pending, arms a command. The next control write of a value v, where v is a multiple of 16 and at most 240, sets the level to v+16.
- R10: If the control write after the command is not a multiple of 16, or is above 240, the level is unchanged. The pending command is cleared whether or not the value was accepted.
- R11: A control write of any value other than 5, made with no command pending, has no effect. Status bits 7, 6, 3, 2 and 1 always read 0.
- R12: After reset, `host_rdata` is 0x00, `ctl_out_valid` is 0, `ctl_in_ready` is 1, and a status read returns 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register in the block |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Host register offset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_rdata | output | 8 | Registered read data, updated on the edge that samples `host_rd` |
| ctl_in_data | input | 8 | Controller byte toward the host |
| ctl_in_valid | input | 1 | Controller offers `ctl_in_data` |
| ctl_in_ready | output | 1 | Controller-to-host FIFO can accept a byte |
| ctl_out_data | output | 8 | Oldest byte from the host |
| ctl_out_valid | output | 1 | `ctl_out_data` holds a byte |
| ctl_out_ready | input | 1 | Controller takes the presented byte |

## Verification
The bench drives both the read and the write FIFO exactly to their limits. At the write limit, a design that judges fullness after the same cycle's pop would take the 273rd byte instead of dropping it, and one with a non-sticky loss flag would clear bit 0 once drained. The almost-full flag is checked one byte below and at each programmed level (16, 48, 256). A design with an off-by-one compare, or one that took a stray control write as a level, would show the flag toggling one byte early or late. The bench also checks rejected level values and an empty-FIFO data read. A design that forgot to clear the pending command, or that popped or returned stale data on an empty read, would misreport the later flags or return a byte other than 0xFF.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int          ADDR_W      = 2;
  localparam int          DATA_W      = 8;
  localparam logic [1:0]  OFS_DATA    = 2'd1;
  localparam logic [1:0]  OFS_CTRL    = 2'd3;
  localparam logic [7:0]  EMPTY_BYTE  = 8'hFF;
  localparam int          ST_RD_EMPTY = 5;
  localparam int          ST_WR_AFULL = 4;
  localparam int          ST_LOST     = 0;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = store[rptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // R3 / R4: the owner must never push into a full FIFO
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5 / R2: never pop an empty FIFO
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/mbx_level_ctl.sv
module mbx_level_ctl #(
  parameter int         STEP      = 16,
  parameter int         MAX_LEVEL = 256,
  parameter logic [7:0] CMD_CODE  = 8'd5,
  localparam int LW = $clog2(MAX_LEVEL + 1),
  localparam int SB = $clog2(STEP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_data,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] STEP_L   = LW'(STEP);
  localparam logic [LW-1:0] MAX_L    = LW'(MAX_LEVEL);
  localparam logic [7:0]    TOP_CODE = 8'(MAX_LEVEL - STEP);

  logic armed;
  logic code_ok;

  assign code_ok = (cfg_data[SB-1:0] == '0) && (cfg_data <= TOP_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      level <= STEP_L;
    end else if (cfg_wr) begin
      if (armed) begin
        armed <= 1'b0;
        if (code_ok) level <= LW'(cfg_data) + STEP_L;
      end else if (cfg_data == CMD_CODE) begin
        armed <= 1'b1;
      end
    end
  end

  assert_level_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= STEP_L) && (level <= MAX_L) && (level[SB-1:0] == '0));
  assert_level_only_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> $past(armed && cfg_wr));
  assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cfg_wr) |=> !armed);
endmodule

// File: rtl/mbx_host_mailbox.sv
module mbx_host_mailbox
  import mbx_pkg::*;
#(
  parameter int H2C_DEPTH = 272,
  parameter int C2H_DEPTH = 16,
  parameter int STEP      = 16,
  parameter int MAX_LEVEL = 256,
  localparam int HCW = $clog2(H2C_DEPTH + 1),
  localparam int CCW = $clog2(C2H_DEPTH + 1),
  localparam int LW  = $clog2(MAX_LEVEL + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  host_addr,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  input  logic        host_rd,
  output logic [7:0]  host_rdata,
  input  logic [7:0]  ctl_in_data,
  input  logic        ctl_in_valid,
  output logic        ctl_in_ready,
  output logic [7:0]  ctl_out_data,
  output logic        ctl_out_valid,
  input  logic        ctl_out_ready
);
  logic           h2c_push, h2c_pop, h2c_full, h2c_empty;
  logic [HCW-1:0] h2c_count;
  logic           c2h_push, c2h_pop, c2h_full, c2h_empty;
  logic [CCW-1:0] c2h_count;
  logic [7:0]     c2h_head;
  logic [LW-1:0]  af_level;
  logic           lost;
  logic [7:0]     status;
  logic           wr_data, wr_ctrl, rd_data;

  assign wr_data = host_wr && (host_addr == OFS_DATA);
  assign wr_ctrl = host_wr && (host_addr == OFS_CTRL);
  assign rd_data = host_rd && (host_addr == OFS_DATA);

  assign h2c_push = wr_data && !h2c_full;
  assign h2c_pop  = ctl_out_valid && ctl_out_ready;
  assign c2h_push = ctl_in_valid && ctl_in_ready;
  assign c2h_pop  = rd_data && !c2h_empty;

  mbx_fifo #(.WIDTH(DATA_W), .DEPTH(H2C_DEPTH)) u_h2c (
    .clk(clk), .rst_n(rst_n), .push(h2c_push), .din(host_wdata),
    .pop(h2c_pop), .dout(ctl_out_data), .count(h2c_count),
    .full(h2c_full), .empty(h2c_empty));

  mbx_fifo #(.WIDTH(DATA_W), .DEPTH(C2H_DEPTH)) u_c2h (
    .clk(clk), .rst_n(rst_n), .push(c2h_push), .din(ctl_in_data),
    .pop(c2h_pop), .dout(c2h_head), .count(c2h_count),
    .full(c2h_full), .empty(c2h_empty));

  mbx_level_ctl #(.STEP(STEP), .MAX_LEVEL(MAX_LEVEL)) u_level (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr_ctrl), .cfg_data(host_wdata),
    .level(af_level));

  assign ctl_out_valid = !h2c_empty;
  assign ctl_in_ready  = !c2h_full;

  always_comb begin
    status              = '0;
    status[ST_RD_EMPTY] = c2h_empty;
    status[ST_WR_AFULL] = (HCW'(af_level) <= h2c_count);
    status[ST_LOST]     = lost;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lost <= 1'b0;
    else if (wr_data && h2c_full) lost <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (host_addr)
        OFS_DATA: host_rdata <= c2h_empty ? EMPTY_BYTE : c2h_head;
        OFS_CTRL: host_rdata <= status;
        default:  host_rdata <= '0;
      endcase
    end
  end

  assert_empty_read_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && c2h_empty) |=> (host_rdata == EMPTY_BYTE));
  assert_empty_read_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && c2h_empty && !ctl_in_valid) |=> c2h_empty);
  assert_lost_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> lost);
  assert_drop_sets_lost_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && h2c_full) |=> lost);
  assert_in_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c2h_count == CCW'(C2H_DEPTH)) |-> !ctl_in_ready);
endmodule

// File: tb/mbx_host_mailbox_bench.sv
module mbx_host_mailbox_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [7:0] ctl_in_data = '0;
  logic       ctl_in_valid = 1'b0;
  logic       ctl_in_ready;
  logic [7:0] ctl_out_data;
  logic       ctl_out_valid;
  logic       ctl_out_ready = 1'b0;

  always #10 clk = ~clk;

  mbx_host_mailbox u_mbx_host_mailbox (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .ctl_in_data(ctl_in_data), .ctl_in_valid(ctl_in_valid),
    .ctl_in_ready(ctl_in_ready), .ctl_out_data(ctl_out_data),
    .ctl_out_valid(ctl_out_valid), .ctl_out_ready(ctl_out_ready));

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_h2c[$];
  logic [7:0] m_c2h[$];
  int         m_level = 16;
  bit         m_armed = 0, m_lost = 0;
  logic [7:0] m_rdata = 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      int hsz, csz;
      hsz = m_h2c.size();
      csz = m_c2h.size();
      if (host_rd) begin
        case (host_addr)
          2'd1: m_rdata = (csz > 0) ? m_c2h.pop_front() : 8'hFF;
          2'd3: m_rdata = {2'b00, csz == 0, hsz >= m_level, 3'b000, m_lost};
          default: m_rdata = 8'h00;
        endcase
      end
      if (ctl_in_valid && csz < 16) m_c2h.push_back(ctl_in_data);
      if (ctl_out_ready && hsz > 0) void'(m_h2c.pop_front());
      if (host_wr && host_addr == 2'd1) begin
        if (hsz < 272) m_h2c.push_back(host_wdata);
        else m_lost = 1;
      end
      if (host_wr && host_addr == 2'd3) begin
        if (m_armed) begin
          if (host_wdata % 16 == 0 && host_wdata <= 240) m_level = host_wdata + 16;
          m_armed = 0;
        end else if (host_wdata == 8'd5) begin
          m_armed = 1;
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ctl_out_valid == (m_h2c.size() > 0), "R2 ctl_out_valid", ctl_out_valid, m_h2c.size() > 0);
      if (m_h2c.size() > 0)
        chk(ctl_out_data == m_h2c[0], "R2 ctl_out_data order", ctl_out_data, m_h2c[0]);
      chk(ctl_in_ready == (m_c2h.size() < 16), "R4 ctl_in_ready", ctl_in_ready, m_c2h.size() < 16);
      chk(host_rdata == m_rdata, "R5 host_rdata vs model", host_rdata, m_rdata);
    end
  end

  task automatic hw(input logic [1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [1:0] a, output logic [7:0] v);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic cpush(input logic [7:0] d);
    ctl_in_data = d; ctl_in_valid = 1'b1;
    @(negedge clk);
    ctl_in_valid = 1'b0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) hw(2'd1, 8'(i));
  endtask

  task automatic drain();
    ctl_out_ready = 1'b1;
    while (ctl_out_valid) @(negedge clk);
    ctl_out_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk(host_rdata == 8'h00, "R12 reset rdata", host_rdata, 8'h00);
    chk(ctl_out_valid == 1'b0, "R12 reset ctl_out_valid", ctl_out_valid, 0);
    chk(ctl_in_ready == 1'b1, "R12 reset ctl_in_ready", ctl_in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    hr(2'd3, v);
    chk(v == 8'h20, "R12 R7 R11 reset status", v, 8'h20);

    // R6: empty read
    hr(2'd1, v);
    chk(v == 8'hFF, "R6 empty read", v, 8'hFF);
    hr(2'd3, v);
    chk(v == 8'h20, "R6 state unchanged", v, 8'h20);

    // R5 / R7: controller bytes read by host
    cpush(8'hA1); cpush(8'hB2); cpush(8'hC3);
    hr(2'd3, v);
    chk(v == 8'h00, "R7 data waiting", v, 8'h00);
    hr(2'd1, v); chk(v == 8'hA1, "R5 first byte", v, 8'hA1);
    hr(2'd1, v); chk(v == 8'hB2, "R5 second byte", v, 8'hB2);
    hr(2'd1, v); chk(v == 8'hC3, "R5 third byte", v, 8'hC3);
    hr(2'd1, v); chk(v == 8'hFF, "R6 empty after drain", v, 8'hFF);

    // R4: fill controller-to-host FIFO
    for (int i = 0; i < 16; i++) cpush(8'(8'h40 + i));
    chk(ctl_in_ready == 1'b0, "R4 ready low when full", ctl_in_ready, 0);
    cpush(8'hEE);
    for (int i = 0; i < 16; i++) begin
      hr(2'd1, v);
      chk(v == 8'(8'h40 + i), "R4 R5 full FIFO contents", v, 8'h40 + i);
    end
    hr(2'd1, v);
    chk(v == 8'hFF, "R4 byte offered while full not taken", v, 8'hFF);

    // R2: host to controller with gaps in ready
    for (int i = 0; i < 5; i++) hw(2'd1, 8'(8'h10 + i));
    for (int i = 0; i < 5; i++) begin
      chk(ctl_out_valid && ctl_out_data == 8'(8'h10 + i), "R2 stream order", ctl_out_data, 8'h10 + i);
      ctl_out_ready = 1'b1; @(negedge clk);
      ctl_out_ready = 1'b0; @(negedge clk);
    end
    chk(ctl_out_valid == 1'b0, "R2 stream empty", ctl_out_valid, 0);

    // R8: default level 16
    fill(15); hr(2'd3, v);
    chk(v[4] == 1'b0, "R8 15 below level 16", v[4], 0);
    fill(1); hr(2'd3, v);
    chk(v[4] == 1'b1, "R8 16 at level 16", v[4], 1);
    drain();

    // R9: level 48
    hw(2'd3, 8'd5); hw(2'd3, 8'd32);
    fill(47); hr(2'd3, v);
    chk(v[4] == 1'b0, "R9 47 below level 48", v[4], 0);
    fill(1); hr(2'd3, v);
    chk(v[4] == 1'b1, "R9 48 at level 48", v[4], 1);
    drain();

    // R10: rejected values keep level 48
    hw(2'd3, 8'd5); hw(2'd3, 8'd37);
    hw(2'd3, 8'd5); hw(2'd3, 8'd250);
    // R11: stray control write (pending already cleared)
    hw(2'd3, 8'd0);
    fill(47); hr(2'd3, v);
    chk(v[4] == 1'b0, "R10 R11 level kept at 48 (47)", v[4], 0);
    fill(1); hr(2'd3, v);
    chk(v[4] == 1'b1, "R10 level kept at 48 (48)", v[4], 1);
    chk(v == 8'h30, "R11 reserved bits zero", v, 8'h30);
    drain();

    // R1: unused offsets
    hw(2'd0, 8'h5A); hw(2'd2, 8'h05); hw(2'd2, 8'h00);
    hr(2'd0, v); chk(v == 8'h00, "R1 offset 0 reads zero", v, 0);
    hr(2'd2, v); chk(v == 8'h00, "R1 offset 2 reads zero", v, 0);
    chk(ctl_out_valid == 1'b0, "R1 offset 0 write not queued", ctl_out_valid, 0);
    fill(47); hr(2'd3, v);
    chk(v == 8'h20, "R1 writes to 2 left level at 48", v, 8'h20);
    drain();

    // R9: maximum level 256
    hw(2'd3, 8'd5); hw(2'd3, 8'd240);
    fill(255); hr(2'd3, v);
    chk(v[4] == 1'b0, "R9 255 below level 256", v[4], 0);
    fill(1); hr(2'd3, v);
    chk(v[4] == 1'b1, "R9 256 at level 256", v[4], 1);

    // R3: fill to 272, then overflow; a pop in the same cycle does not save it
    fill(16);
    chk(v[0] == 1'b0, "R3 no loss yet", v[0], 0);
    host_addr = 2'd1; host_wdata = 8'hAB; host_wr = 1'b1; ctl_out_ready = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; ctl_out_ready = 1'b0;
    hr(2'd3, v);
    chk(v == 8'h31, "R3 loss flagged", v, 8'h31);
    drain();
    hr(2'd3, v);
    chk(v == 8'h21, "R3 loss flag sticky", v, 8'h21);

    done = 1;
    summary();
    $finish;
  end
endmodule